// File: doc/BRIEF.md
# Streaming Line Buffer with Stencil Window Flag

This block sits in a pixel pipeline and delays a stream of 16-bit samples by exactly one image line. Each accepted sample is stored in a circular buffer whose length (the line depth) comes from a packed configuration word. The sample stored one line earlier appears on `data_out` during the same cycle in which the new sample is offered. A neighbour can therefore combine a pixel with the pixel directly above it without any extra alignment.

Alongside the delayed data, the block raises `valid_out` whenever a stencil window of the configured width is complete across the current row and the row above it. The flag is computed from a column position that wraps at the line depth and a flag that records that the first row has been seen. It stays low for the whole first row. In every later row it stays low for the leftmost width-minus-one columns.

Only accepted writes move the stream. A write is accepted when `wen_in` is high, the block is enabled and in line-buffer mode, and no configuration write occurs in the same cycle.

Top module: `line_buffer_stencil`

## Requirements
- R1: The configuration word is packed as follows: bits [2:0] hold the mode, bits [12:3] the line depth, bits [16:13] the stencil width and bit 17 the enable. Mode value 4 selects line-buffer operation. A cycle with `cfg_we` high loads the word, ignores any write in that cycle, and restarts the stream so that the next accepted write counts as sample 0.
- R2: Once at least depth writes have been accepted, `data_out` equals the `data_in` value of the write accepted exactly depth accepted writes earlier. The value is visible in the cycle in which the new sample is offered, before the clock edge that accepts it.
- R3: While fewer than depth writes have been accepted since the last restart, `data_out` is 0.
- R4: A cycle with `wen_in` low changes neither `data_out` nor `valid_out`, and shifts no stored sample.
- R5: While the enable bit is 0, or the mode is not 4, writes are ignored: `data_out` and `valid_out` stay 0.
- R6: Counting accepted writes i from 0 after a restart, `valid_out` is 0 for i < depth + width - 1 and 1 for depth + width - 1 <= i < 2*depth.
- R7: In every row after the first, `valid_out` is 0 for the first width-1 samples of the row and 1 for the rest of the row.
- R8: A depth field of 0 acts as depth 1, and a depth above MAX_DEPTH (512) acts as MAX_DEPTH. A stencil width of 0 acts as width 1.
- R9: Reset clears the configuration (so the block is disabled) and clears the position counters, with `data_out` and `valid_out` at 0. Reset does not clear the memory, and old memory contents never reach `data_out` after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the configuration word this cycle |
| cfg_word | input | 18 | Packed configuration: mode, depth, width, enable |
| wen_in | input | 1 | Offer `data_in` as the next stream sample |
| data_in | input | 16 | Incoming sample |
| data_out | output | 16 | Sample accepted one line earlier, or 0 during the first row |
| valid_out | output | 1 | A full stencil window is available |

## Verification
Depths 1, 2, 3, 5 and 8 are each combined with widths 1 to 4. Every combination streams three lines plus a few samples with a repeating gap in `wen_in`. The gaps separate counting of cycles from counting of accepted writes, and the width sweep, including widths greater than the depth, places the low stretch of the valid flag at the start of each row. Further streams run with the enable bit cleared and with a foreign mode value to show that writes are ignored. Depth fields of 0 and above the maximum check the clamping. A configuration rewrite in mid-stream and a reset with a stale memory check that old contents are hidden during the first row.

// File: rtl/lb_pkg.sv
package lb_pkg;
  localparam int CFG_W      = 18;
  localparam int MODE_FW    = 3;
  localparam int DEPTH_FW   = 10;
  localparam int SW_FW      = 4;
  localparam int MODE_LSB   = 0;
  localparam int DEPTH_LSB  = 3;
  localparam int SW_LSB     = 13;
  localparam int EN_BIT     = 17;
  localparam logic [MODE_FW-1:0] MODE_LINEBUF = 3'd4;

  typedef struct packed {
    logic                tile_on;
    logic [SW_FW-1:0]    win_w;
    logic [DEPTH_FW-1:0] line_len;
    logic [MODE_FW-1:0]  mode;
  } lb_cfg_t;
endpackage

// File: rtl/lb_cfg_reg.sv
module lb_cfg_reg
  import lb_pkg::*;
#(
  parameter int MAX_DEPTH = 512,
  localparam int AW = $clog2(MAX_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_word,
  output logic                active,
  output logic [AW-1:0]       depth_m1,
  output logic [SW_FW-1:0]    sw_m1
);
  lb_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = lb_cfg_t'(cfg_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    active = cfg_q.tile_on && (cfg_q.mode == MODE_LINEBUF);
    if (cfg_q.line_len == '0)
      depth_m1 = '0;
    else if (int'(cfg_q.line_len) > MAX_DEPTH)
      depth_m1 = AW'(MAX_DEPTH - 1);
    else
      depth_m1 = AW'(cfg_q.line_len - 1'b1);
    if (cfg_q.win_w == '0) sw_m1 = '0;
    else                   sw_m1 = cfg_q.win_w - 1'b1;
  end
endmodule

// File: rtl/lb_pos_ctr.sv
module lb_pos_ctr #(
  parameter int AW   = 9,
  parameter int SW_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            adv,
  input  logic [AW-1:0]   depth_m1,
  input  logic [SW_W-1:0] sw_m1,
  output logic [AW-1:0]   col,
  output logic            row_seen,
  output logic            win_ok
);
  logic [AW-1:0] col_d;
  logic          row_d;
  logic          at_end;
  localparam int CW = (AW > SW_W) ? AW : SW_W;

  assign at_end = (col == depth_m1);

  always_comb begin
    col_d = col;
    row_d = row_seen;
    if (restart) begin
      col_d = '0;
      row_d = 1'b0;
    end else if (adv) begin
      col_d = at_end ? '0 : col + 1'b1;
      row_d = row_seen | at_end;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col      <= '0;
      row_seen <= 1'b0;
    end else begin
      col      <= col_d;
      row_seen <= row_d;
    end
  end

  assign win_ok = row_seen && (CW'(col) >= CW'(sw_m1));
endmodule

// File: rtl/lb_store.sv
module lb_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/line_buffer_stencil.sv
module line_buffer_stencil
  import lb_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_DEPTH = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              wen_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              valid_out
);
  localparam int AW = $clog2(MAX_DEPTH);

  logic              active;
  logic [AW-1:0]     depth_m1;
  logic [SW_FW-1:0]  sw_m1;
  logic [AW-1:0]     col;
  logic              row_seen;
  logic              win_ok;
  logic              adv;
  logic [DATA_W-1:0] rd_word;

  assign adv = wen_in && active && !cfg_we;

  lb_cfg_reg #(.MAX_DEPTH(MAX_DEPTH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .active(active), .depth_m1(depth_m1), .sw_m1(sw_m1)
  );

  lb_pos_ctr #(.AW(AW), .SW_W(SW_FW)) u_pos (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we), .adv(adv),
    .depth_m1(depth_m1), .sw_m1(sw_m1),
    .col(col), .row_seen(row_seen), .win_ok(win_ok)
  );

  lb_store #(.DATA_W(DATA_W), .DEPTH(MAX_DEPTH)) u_mem (
    .clk(clk), .we(adv), .addr(col), .wdata(data_in), .rdata(rd_word)
  );

  assign data_out  = row_seen ? rd_word : '0;
  assign valid_out = win_ok;
endmodule

// File: rtl/lb_chk.sv
module lb_chk #(
  parameter int AW   = 9,
  parameter int DW   = 16,
  parameter int SW_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            wen_in,
  input logic [DW-1:0]   data_out,
  input logic            valid_out,
  input logic [AW-1:0]   col,
  input logic            row_seen,
  input logic            active,
  input logic [AW-1:0]   depth_m1,
  input logic [SW_W-1:0] sw_m1
);
  localparam int CW = (AW > SW_W) ? AW : SW_W;

  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (col == '0 && !row_seen));

  p_col_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col <= depth_m1);

  p_zero_first_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !row_seen |-> data_out == '0);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wen_in && !cfg_we) |=> ($stable(col) && $stable(row_seen)));

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cfg_we) |=> ($stable(col) && $stable(row_seen)));

  p_first_row_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !row_seen |-> !valid_out);

  p_window_cols_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> CW'(col) >= CW'(sw_m1));
endmodule

bind line_buffer_stencil lb_chk #(.AW(AW), .DW(DATA_W), .SW_W(lb_pkg::SW_FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wen_in(wen_in),
  .data_out(data_out), .valid_out(valid_out), .col(col),
  .row_seen(row_seen), .active(active), .depth_m1(depth_m1), .sw_m1(sw_m1)
);

// File: tb/line_buffer_stencil_bench.sv
module line_buffer_stencil_bench;
  localparam int PERIOD = 10;
  localparam int MAXD   = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [17:0] cfg_word;
  logic        wen_in;
  logic [15:0] data_in;
  logic [15:0] data_out;
  logic        valid_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] hist [0:1023];
  int n;
  int d_eff;
  int sw_eff;
  bit act;

  always #(PERIOD/2) clk = ~clk;

  line_buffer_stencil u_line_buffer_stencil (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .wen_in(wen_in), .data_in(data_in), .data_out(data_out), .valid_out(valid_out)
  );

  task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // R1 packing: mode [2:0], depth [12:3], width [16:13], enable bit 17
  task automatic cfg(input bit en, input int mode, input int depth, input int sw);
    @(negedge clk);
    cfg_we   = 1'b1;
    wen_in   = 1'b1;
    data_in  = 16'hDEAD;
    cfg_word = {en, 4'(sw), 10'(depth), 3'(mode)};
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    wen_in = 1'b0;
    act    = en && (mode == 4);
    d_eff  = (depth == 0) ? 1 : ((depth > MAXD) ? MAXD : depth);
    sw_eff = (sw == 0) ? 1 : sw;
    n      = 0;
  endtask

  task automatic step(input bit w, input logic [15:0] v);
    logic [15:0] exp_d;
    bit exp_v;
    string td, tv;
    @(negedge clk);
    wen_in  = w;
    data_in = v;
    #1;
    exp_d = (n >= d_eff) ? hist[n - d_eff] : 16'd0;
    exp_v = (n >= d_eff) && ((n % d_eff) >= sw_eff - 1);
    td = (n < d_eff) ? "R3" : "R2";
    tv = (n < 2 * d_eff) ? "R6" : "R7";
    if (!w) begin td = "R4"; tv = "R4"; end
    if (!act) begin td = "R5"; tv = "R5"; end
    check(data_out == exp_d, {td, " data_out"}, data_out, exp_d);
    check(valid_out == exp_v, {tv, " valid_out"}, valid_out, exp_v);
    @(posedge clk);
    if (w && act) begin
      hist[n] = v;
      n++;
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int depths [5] = '{1, 2, 3, 5, 8};
    rst_n = 1'b0; cfg_we = 1'b0; cfg_word = '0; wen_in = 1'b0; data_in = '0;
    act = 0; d_eff = 1; sw_eff = 1; n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(data_out == 16'd0, "R9 reset data_out", data_out, 0);
    check(valid_out == 1'b0, "R9 reset valid_out", valid_out, 0);
    // R5: block disabled after reset, writes ignored
    for (int k = 0; k < 6; k++) step(1'b1, 16'(100 + k));

    // Main sweep: R2 R3 R4 R6 R7
    foreach (depths[di]) begin
      for (int sw = 1; sw <= 4; sw++) begin
        cfg(1'b1, 4, depths[di], sw);
        for (int k = 0; k < 3 * depths[di] + 3; k++)
          step((k % 5) != 3, 16'(k * 37 + depths[di] * 11 + sw * 3));
      end
    end

    // R5: enable cleared, and foreign mode
    cfg(1'b0, 4, 3, 1);
    for (int k = 0; k < 8; k++) step(1'b1, 16'(k + 5));
    cfg(1'b1, 3, 3, 1);
    for (int k = 0; k < 8; k++) step(1'b1, 16'(k + 9));

    // R1: rewrite of the configuration mid-stream restarts counting
    cfg(1'b1, 4, 4, 2);
    for (int k = 0; k < 7; k++) step(1'b1, 16'(k + 300));
    cfg(1'b1, 4, 4, 2);
    for (int k = 0; k < 10; k++) step(1'b1, 16'(k + 400));

    // R8: clamping of depth and width
    cfg(1'b1, 4, 0, 0);
    for (int k = 0; k < 6; k++) step(1'b1, 16'(k * 5 + 1));
    cfg(1'b1, 4, 700, 3);
    for (int k = 0; k < MAXD + 6; k++) step(1'b1, 16'(k ^ 16'h5A5A));

    // R9: reset mid-stream, stale memory stays hidden
    cfg(1'b1, 4, 3, 1);
    for (int k = 0; k < 5; k++) step(1'b1, 16'(k + 700));
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(data_out == 16'd0, "R9 in-reset data_out", data_out, 0);
    check(valid_out == 1'b0, "R9 in-reset valid_out", valid_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    act = 0; n = 0;
    step(1'b1, 16'd1);
    cfg(1'b1, 4, 3, 1);
    for (int k = 0; k < 8; k++) step(1'b1, 16'(k + 900));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule